// File: doc/BRIEF.md
# Edge Interrupt Controller

This block gathers a parameterised set of external input lines and turns selected signal edges into interrupt requests for a small processor. Each line passes through a two-stage synchroniser and a one-cycle history stage. A transition can then set that line's latched request bit. Whether a rising transition, a falling transition, both or neither count is chosen per line by two selection registers. Software can also raise any line by writing a set-only trigger register. Latched requests stay set until software writes a one to that bit in the request register, which also re-arms the software trigger for that line.

Software reaches the block through a simple memory-mapped port that takes only full 32-bit accesses. An access of any other size, a misaligned address or an address beyond the last register is flagged on a bad-access output in the same cycle. Such an access reads as zero and changes nothing. Every line has its own interrupt output, driven while its request bit and its enable bit are both set, and one combined output is the OR of all of them. An event-mask register keeps its slot in the address map, but it stores nothing and has no effect.

Top module: `edge_irq_ctrl`

## Requirements
- R1: After a cycle with `rstN` low, every register reads zero and `irqOut` and `irqAny` are low.
- R2: The enable register at byte offset 0x00 reads back the last value written to it, limited to the low LINES bits; all upper bits read zero.
- R3: A write to the event-mask register at byte offset 0x04 is a valid access (no bad flag) with no effect, and a read of it always returns zero.
- R4: The rising-select register (offset 0x08) and the falling-select register (offset 0x0C) read back what was written. A line change applied before clock edge k sets the request bit at edge k+2 when the matching select bit is 1, and has no effect when it is 0.
- R5: The software-trigger register is at offset 0x10. Writing 1 to a bit that reads 0 sets that bit and sets the line's request bit. Writing 1 to a set bit, or 0 to any bit, leaves both registers unchanged.
- R6: The request register is at offset 0x14. Writing 1 to a bit clears it and also clears the same bit of the software-trigger register, so a later trigger write fires again. Writing 0 leaves the bit unchanged.
- R7: When a hardware edge sets a request bit in the same cycle that a write tries to clear it, the bit ends up set.
- R8: `irqOut[i]` is high exactly while request bit i and enable bit i are both 1, and `irqAny` is the OR of `irqOut`; after a write of zero to the enable register both are low in the next cycle.
- R9: An access is valid only when `busSize` is 2 (word; 0 is byte, 1 is half-word), `busAddr[1:0]` is 0 and the offset is at most 0x14. Any other selected access raises `badAccess` in the same cycle, reads as zero and changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| lineIn | input | LINES | Asynchronous external input lines |
| busSel | input | 1 | Access strobe, one cycle per access |
| busWrite | input | 1 | 1 for a write, 0 for a read |
| busAddr | input | ADDR_W | Byte offset of the access |
| busSize | input | 2 | Access size code: 0 byte, 1 half-word, 2 word |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid in the cycle of a read access |
| badAccess | output | 1 | High during a selected access that is not valid |
| irqOut | output | LINES | Per-line interrupt requests |
| irqAny | output | 1 | OR of all per-line requests |

## Verification
Two functions can act on one request bit in the same clock: a synchronised hardware edge that sets it and a write of one that clears it. The bench provokes this by moving a line exactly two clock edges before a clear write to the request register lands, so both act at the same edge. It expects the bit to read back as set afterwards. The same situation is judged on every clock by a behavioural model, which keeps its own history of line samples and applies set-over-clear to decide the request and interrupt values.

// File: rtl/eirq_pkg.sv
package eirq_pkg;

  localparam int DATA_W    = 32;
  localparam int NUM_REGS  = 6;
  localparam logic [1:0] SIZE_WORD = 2'd2;

  // Register slot index, taken from byte offset bits [4:2].
  typedef enum logic [2:0] {
    SLOT_ENABLE = 3'd0,
    SLOT_EVENT  = 3'd1,
    SLOT_RISE   = 3'd2,
    SLOT_FALL   = 3'd3,
    SLOT_SWTRIG = 3'd4,
    SLOT_REQ    = 3'd5
  } slot_e;

  // Strobes from the bus decoder to the register datapath.
  typedef struct packed {
    logic  wrEnable;
    logic  wrRise;
    logic  wrFall;
    logic  wrSwTrig;
    logic  wrReq;
    logic  rdEn;
    slot_e rdSlot;
  } strobes_t;

endpackage

// File: rtl/eirq_bus_ctrl.sv
module eirq_bus_ctrl
  import eirq_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [1:0]        busSize,
  output strobes_t          stb,
  output logic              badAccess
);

  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] slotIdx;
  logic             aligned;
  logic             mapped;
  logic             validAcc;
  logic             doWrite;
  slot_e            slot;

  assign slotIdx  = busAddr[ADDR_W-1:2];
  assign aligned  = (busAddr[1:0] == 2'b00);
  assign mapped   = (slotIdx < IDX_W'(NUM_REGS));
  assign validAcc = busSel && (busSize == SIZE_WORD) && aligned && mapped;
  assign slot     = slot_e'(slotIdx[2:0]);
  assign doWrite  = validAcc && busWrite;

  assign badAccess = busSel && !validAcc;

  always_comb begin
    stb          = '0;
    stb.rdEn     = validAcc && !busWrite;
    stb.rdSlot   = slot;
    stb.wrEnable = doWrite && (slot == SLOT_ENABLE);
    stb.wrRise   = doWrite && (slot == SLOT_RISE);
    stb.wrFall   = doWrite && (slot == SLOT_FALL);
    stb.wrSwTrig = doWrite && (slot == SLOT_SWTRIG);
    stb.wrReq    = doWrite && (slot == SLOT_REQ);
    // Event-mask writes decode as valid but raise no strobe.
  end

endmodule

// File: rtl/eirq_line_sync.sv
module eirq_line_sync (
  input  logic clk,
  input  logic rstN,
  input  logic lineRaw,
  output logic roseNow,
  output logic fellNow
);

  logic stage1;
  logic stage2;
  logic lastLvl;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stage1  <= 1'b0;
      stage2  <= 1'b0;
      lastLvl <= 1'b0;
    end else begin
      stage1  <= lineRaw;
      stage2  <= stage1;
      lastLvl <= stage2;
    end
  end

  assign roseNow = stage2 && !lastLvl;
  assign fellNow = !stage2 && lastLvl;

endmodule

// File: rtl/eirq_datapath.sv
module eirq_datapath
  import eirq_pkg::*;
#(
  parameter int LINES = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [LINES-1:0]  lineIn,
  input  strobes_t          stb,
  input  logic [LINES-1:0]  wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [LINES-1:0]  irqVec
);

  logic [LINES-1:0] enableReg;
  logic [LINES-1:0] riseSel;
  logic [LINES-1:0] fallSel;
  logic [LINES-1:0] swTrig;
  logic [LINES-1:0] reqReg;
  logic [LINES-1:0] roseVec;
  logic [LINES-1:0] fellVec;
  logic [LINES-1:0] reqNext;
  logic [LINES-1:0] swNext;

  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic swFire;
    logic setReq;
    logic clrReq;

    eirq_line_sync syncI (
      .clk     (clk),
      .rstN    (rstN),
      .lineRaw (lineIn[i]),
      .roseNow (roseVec[i]),
      .fellNow (fellVec[i])
    );

    assign swFire = stb.wrSwTrig && wrData[i] && !swTrig[i];
    assign setReq = (roseVec[i] && riseSel[i]) || (fellVec[i] && fallSel[i]) || swFire;
    assign clrReq = stb.wrReq && wrData[i];

    // Set has priority over write-one-to-clear.
    assign reqNext[i] = setReq ? 1'b1 : (clrReq ? 1'b0 : reqReg[i]);
    assign swNext[i]  = swFire ? 1'b1 : (clrReq ? 1'b0 : swTrig[i]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enableReg <= '0;
      riseSel   <= '0;
      fallSel   <= '0;
      swTrig    <= '0;
      reqReg    <= '0;
    end else begin
      if (stb.wrEnable) enableReg <= wrData;
      if (stb.wrRise)   riseSel   <= wrData;
      if (stb.wrFall)   fallSel   <= wrData;
      swTrig <= swNext;
      reqReg <= reqNext;
    end
  end

  always_comb begin
    rdData = '0;
    if (stb.rdEn) begin
      unique case (stb.rdSlot)
        SLOT_ENABLE: rdData = DATA_W'(enableReg);
        SLOT_RISE:   rdData = DATA_W'(riseSel);
        SLOT_FALL:   rdData = DATA_W'(fallSel);
        SLOT_SWTRIG: rdData = DATA_W'(swTrig);
        SLOT_REQ:    rdData = DATA_W'(reqReg);
        default:     rdData = '0;
      endcase
    end
  end

  assign irqVec = reqReg & enableReg;

endmodule

// File: rtl/edge_irq_ctrl.sv
module edge_irq_ctrl
  import eirq_pkg::*;
#(
  parameter int LINES  = 20,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [LINES-1:0]  lineIn,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [1:0]        busSize,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              badAccess,
  output logic [LINES-1:0]  irqOut,
  output logic              irqAny
);

  strobes_t stb;

  eirq_bus_ctrl #(.ADDR_W(ADDR_W)) ctrlI (
    .busSel    (busSel),
    .busWrite  (busWrite),
    .busAddr   (busAddr),
    .busSize   (busSize),
    .stb       (stb),
    .badAccess (badAccess)
  );

  eirq_datapath #(.LINES(LINES)) dpI (
    .clk    (clk),
    .rstN   (rstN),
    .lineIn (lineIn),
    .stb    (stb),
    .wrData (busWdata[LINES-1:0]),
    .rdData (busRdata),
    .irqVec (irqOut)
  );

  if (LINES < DATA_W) begin : g_spare
    logic unusedHiBits;
    assign unusedHiBits = ^busWdata[DATA_W-1:LINES];
  end

  assign irqAny = |irqOut;

endmodule

// File: rtl/eirq_checker.sv
module eirq_checker #(
  parameter int LINES  = 20,
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic              busSel,
  input logic              busWrite,
  input logic [ADDR_W-1:0] busAddr,
  input logic [31:0]       busWdata,
  input logic [31:0]       busRdata,
  input logic              badAccess,
  input logic [LINES-1:0]  irqOut,
  input logic              irqAny
);

  logic goodRd;
  logic goodWr;
  logic [ADDR_W-1:0] offEvent;
  logic [ADDR_W-1:0] offSw;

  assign offEvent = ADDR_W'(4);
  assign offSw    = ADDR_W'(16);
  assign goodRd   = busSel && !busWrite && !badAccess;
  assign goodWr   = busSel && busWrite && !badAccess;

  // R1: coming out of reset nothing is requesting
  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (irqOut == '0 && !irqAny));

  // R3: event-mask slot always reads zero
  assert_event_reads_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    (goodRd && busAddr == offEvent) |-> (busRdata == 32'h0));

  // R5: software-trigger bits never drop between two back-to-back reads
  assert_swtrig_no_drop_R5: assert property (@(posedge clk) disable iff (!rstN)
    (goodRd && busAddr == offSw && $past(goodRd) && $past(busAddr) == offSw)
      |-> (($past(busRdata) & ~busRdata) == 32'h0));

  // R8: clearing the enable register silences every output next cycle
  assert_enable_zero_silences_R8: assert property (@(posedge clk) disable iff (!rstN)
    (goodWr && busAddr == ADDR_W'(0) && busWdata == 32'h0) |=> (irqOut == '0 && !irqAny));

  // R9: a bad read returns zero
  assert_bad_read_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busWrite && badAccess) |-> (busRdata == 32'h0));

endmodule

bind edge_irq_ctrl eirq_checker #(.LINES(LINES), .ADDR_W(ADDR_W)) chkI (
  .clk       (clk),
  .rstN      (rstN),
  .busSel    (busSel),
  .busWrite  (busWrite),
  .busAddr   (busAddr),
  .busWdata  (busWdata),
  .busRdata  (busRdata),
  .badAccess (badAccess),
  .irqOut    (irqOut),
  .irqAny    (irqAny)
);

// File: tb/edge_irq_ctrl_tb.sv
module edge_irq_ctrl_tb_top;

  localparam int N = 20;
  localparam logic [N-1:0] ALL1 = '1;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [N-1:0]  lineIn = '0;
  logic          busSel = 1'b0;
  logic          busWrite = 1'b0;
  logic [4:0]    busAddr = '0;
  logic [1:0]    busSize = 2'd2;
  logic [31:0]   busWdata = '0;
  logic [31:0]   busRdata;
  logic          badAccess;
  logic [N-1:0]  irqOut;
  logic          irqAny;

  int checks = 0;
  int errors = 0;
  string phase = "R1";

  always #10 clk = ~clk;

  edge_irq_ctrl #(.LINES(N), .ADDR_W(5)) dut_i (
    .clk(clk), .rstN(rstN), .lineIn(lineIn), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busSize(busSize), .busWdata(busWdata), .busRdata(busRdata),
    .badAccess(badAccess), .irqOut(irqOut), .irqAny(irqAny)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [N-1:0] mEn, mRise, mFall, mSw, mReq;
  logic [N-1:0] hist[$];
  bit mReady = 0;

  function automatic bit accOk(input logic sel, input logic [1:0] sz, input logic [4:0] a);
    return sel && sz == 2'd2 && a[1:0] == 2'b00 && a <= 5'h14;
  endfunction

  function automatic logic [31:0] expRead();
    if (!busSel || busWrite || !accOk(busSel, busSize, busAddr)) return 32'h0;
    case (busAddr)
      5'h00: return 32'(mEn);
      5'h08: return 32'(mRise);
      5'h0C: return 32'(mFall);
      5'h10: return 32'(mSw);
      5'h14: return 32'(mReq);
      default: return 32'h0;
    endcase
  endfunction

  initial begin
    hist.push_front('0); hist.push_front('0); hist.push_front('0);
  end

  always @(posedge clk) begin
    if (!rstN) begin
      mEn = '0; mRise = '0; mFall = '0; mSw = '0; mReq = '0;
      hist.push_front('0);
      mReady = 1;
    end else begin
      logic [N-1:0] older, newer, nReq, nSw;
      bit wr;
      newer = hist[1];
      older = hist[2];
      wr = accOk(busSel, busSize, busAddr) && busWrite;
      nReq = mReq; nSw = mSw;
      for (int i = 0; i < N; i++) begin
        bit fire, setb, clrb;
        fire = wr && busAddr == 5'h10 && busWdata[i] && !mSw[i];
        setb = (newer[i] && !older[i] && mRise[i]) || (!newer[i] && older[i] && mFall[i]) || fire;
        clrb = wr && busAddr == 5'h14 && busWdata[i];
        if (setb) nReq[i] = 1'b1; else if (clrb) nReq[i] = 1'b0;
        if (fire) nSw[i] = 1'b1; else if (clrb) nSw[i] = 1'b0;
      end
      if (wr && busAddr == 5'h00) mEn = busWdata[N-1:0];
      if (wr && busAddr == 5'h08) mRise = busWdata[N-1:0];
      if (wr && busAddr == 5'h0C) mFall = busWdata[N-1:0];
      mReq = nReq; mSw = nSw;
      hist.push_front(lineIn);
    end
    void'(hist.pop_back());
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    #4;
    if (mReady) begin
      chk({"R8 ", phase}, "irqOut", 32'(irqOut), 32'(mReq & mEn));
      chk({"R8 ", phase}, "irqAny", 32'(irqAny), 32'(|(mReq & mEn)));
      chk({"R9 ", phase}, "badAccess", 32'(badAccess), 32'(busSel && !accOk(busSel, busSize, busAddr)));
      if (busSel) chk(phase, "busRdata", busRdata, expRead());
    end
  end

  // ---------------- bus tasks ----------------
  task automatic busOp(input logic wr, input logic [1:0] sz, input logic [4:0] a,
                       input logic [31:0] wd, input logic [31:0] expRd, input logic expBad,
                       input string tag);
    @(negedge clk);
    busSel = 1'b1; busWrite = wr; busSize = sz; busAddr = a; busWdata = wd;
    #4;
    chk(tag, "badAccess(directed)", 32'(badAccess), 32'(expBad));
    if (!wr) chk(tag, "read(directed)", busRdata, expRd);
    @(posedge clk);
    #1;
    busSel = 1'b0; busWrite = 1'b0; busWdata = '0; busSize = 2'd2; busAddr = '0;
  endtask

  task automatic wrReg(input logic [4:0] a, input logic [31:0] wd, input string tag);
    busOp(1'b1, 2'd2, a, wd, 32'h0, 1'b0, tag);
  endtask

  task automatic rdReg(input logic [4:0] a, input logic [31:0] expv, input string tag);
    busOp(1'b0, 2'd2, a, 32'h0, expv, 1'b0, tag);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired in phase %s", phase);
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    phase = "R1";
    rdReg(5'h00, 32'h0, "R1"); rdReg(5'h04, 32'h0, "R1"); rdReg(5'h08, 32'h0, "R1");
    rdReg(5'h0C, 32'h0, "R1"); rdReg(5'h10, 32'h0, "R1"); rdReg(5'h14, 32'h0, "R1");
    chk("R1", "irqOut after reset", 32'(irqOut), 32'h0);

    // R2: enable register, upper bits dropped
    phase = "R2";
    wrReg(5'h00, 32'hFFFF_FFFF, "R2");
    rdReg(5'h00, 32'h000F_FFFF, "R2");
    wrReg(5'h00, 32'h0005_A5A5, "R2");
    rdReg(5'h00, 32'h0005_A5A5, "R2");
    wrReg(5'h00, 32'hFFFF_FFFF, "R2");

    // R3: event mask inert
    phase = "R3";
    wrReg(5'h04, 32'hFFFF_FFFF, "R3");
    rdReg(5'h04, 32'h0, "R3");

    // R4: edge selection and latency
    phase = "R4";
    wrReg(5'h08, 32'h0000_000F, "R4");
    wrReg(5'h0C, 32'h0000_0030, "R4");
    rdReg(5'h08, 32'h0000_000F, "R4");
    rdReg(5'h0C, 32'h0000_0030, "R4");
    @(negedge clk); lineIn = 20'h00033;
    idle(4);
    rdReg(5'h14, 32'h0000_0003, "R4 rising");
    @(negedge clk); lineIn = '0;
    idle(4);
    rdReg(5'h14, 32'h0000_0033, "R4 falling");
    wrReg(5'h14, 32'(ALL1), "R4");
    rdReg(5'h14, 32'h0, "R4");
    @(negedge clk); lineIn[2] = 1'b1;
    rdReg(5'h14, 32'h0, "R4 latency edge k");
    rdReg(5'h14, 32'h0, "R4 latency edge k+1");
    rdReg(5'h14, 32'h0000_0004, "R4 latency edge k+2");
    @(negedge clk); lineIn[2] = 1'b0;
    idle(4);
    rdReg(5'h14, 32'h0000_0004, "R4 no fall select");
    wrReg(5'h14, 32'(ALL1), "R4");

    // R5: software trigger
    phase = "R5";
    wrReg(5'h10, 32'h0000_0100, "R5");
    rdReg(5'h10, 32'h0000_0100, "R5");
    rdReg(5'h14, 32'h0000_0100, "R5");
    wrReg(5'h10, 32'h0, "R5 write zero");
    rdReg(5'h10, 32'h0000_0100, "R5 write zero");
    wrReg(5'h10, 32'h0000_0100, "R5 already set");
    rdReg(5'h10, 32'h0000_0100, "R5 already set");
    rdReg(5'h14, 32'h0000_0100, "R5 already set");

    // R6: write-one-to-clear, re-arm
    phase = "R6";
    wrReg(5'h14, 32'h0, "R6 write zero");
    rdReg(5'h14, 32'h0000_0100, "R6 write zero");
    wrReg(5'h14, 32'h0000_0100, "R6");
    rdReg(5'h14, 32'h0, "R6");
    rdReg(5'h10, 32'h0, "R6 swtrig cleared");
    wrReg(5'h10, 32'h0000_0100, "R6 rearm");
    rdReg(5'h14, 32'h0000_0100, "R6 rearm");
    wrReg(5'h14, 32'(ALL1), "R6");

    // R7: edge set and clear in the same cycle
    phase = "R7";
    wrReg(5'h08, 32'h0000_0080, "R7");
    @(negedge clk); lineIn[7] = 1'b1;
    @(negedge clk);
    wrReg(5'h14, 32'h0000_0080, "R7 collide");
    rdReg(5'h14, 32'h0000_0080, "R7 set wins");
    wrReg(5'h14, 32'(ALL1), "R7");
    rdReg(5'h14, 32'h0, "R7");

    // R8: masking of outputs
    phase = "R8";
    wrReg(5'h00, 32'h0000_0003, "R8");
    wrReg(5'h10, 32'h0000_0201, "R8");
    @(negedge clk); #4;
    chk("R8", "irqOut masked", 32'(irqOut), 32'h0000_0001);
    chk("R8", "irqAny", 32'(irqAny), 32'h1);
    wrReg(5'h00, 32'h0, "R8");
    @(negedge clk); #4;
    chk("R8", "irqOut disabled", 32'(irqOut), 32'h0);
    chk("R8", "irqAny disabled", 32'(irqAny), 32'h0);
    wrReg(5'h00, 32'h0000_0200, "R8");
    @(negedge clk); #4;
    chk("R8", "irqOut other line", 32'(irqOut), 32'h0000_0200);
    wrReg(5'h14, 32'(ALL1), "R8");

    // R9: bad accesses
    phase = "R9";
    wrReg(5'h00, 32'h0, "R9");
    busOp(1'b1, 2'd0, 5'h00, 32'hFFFF_FFFF, 32'h0, 1'b1, "R9 byte write");
    rdReg(5'h00, 32'h0, "R9 byte write ignored");
    busOp(1'b1, 2'd2, 5'h12, 32'hFFFF_FFFF, 32'h0, 1'b1, "R9 misaligned write");
    rdReg(5'h10, 32'h0, "R9 misaligned ignored");
    rdReg(5'h14, 32'h0, "R9 misaligned ignored");
    busOp(1'b0, 2'd2, 5'h18, 32'h0, 32'h0, 1'b1, "R9 unmapped read");
    busOp(1'b1, 2'd2, 5'h1C, 32'hFFFF_FFFF, 32'h0, 1'b1, "R9 unmapped write");
    wrReg(5'h08, 32'h0000_0011, "R9");
    busOp(1'b0, 2'd1, 5'h08, 32'h0, 32'h0, 1'b1, "R9 half read");
    rdReg(5'h08, 32'h0000_0011, "R9");

    idle(3);
    finishRun();
  end

endmodule